// File: doc/BRIEF.md
# DMA Descriptor Validity Checker

The block inspects one linked-list DMA descriptor of sixteen 32-bit words as it streams past, one word per valid beat, in word order. Word 0 carries the control flags, word 3 the line geometry, word 5 the completion flag in its top bit and word 15 an optional additive checksum. Once the last word has been taken, the block issues a single-cycle result pulse carrying a verdict, the decoded control flags, the line size and the line stride in bytes.

The words are kept inside the block and can be read back one at a time through a small index port, with the completion flag forced on in word 5. A fetch engine uses that port to write the descriptor back to memory when done write-back is requested. A start pulse abandons any partial descriptor and arms the block for the next one. The verdict comes from three checks applied in a fixed order, and the first failure found is the one reported.

Top module: `dma_desc_checker`

## Requirements
- R1: Words are taken one per beat with `word_valid` high. In the clock cycle after the beat that takes the sixteenth word, `result_valid` is high for exactly one cycle.
- R2: If bits 7:0 of word 0 differ from 0xA5, the verdict is 1 (bad preamble).
- R3: If bit 20 of word 0 is set, the 32-bit wrapping sum of words 0 to 14 must equal word 15, or the verdict is 2 (checksum mismatch). If bit 20 is clear, word 15 has no effect on the verdict.
- R4: If bit 31 of word 5 is set and bit 10 of word 0 is clear, the verdict is 3 (already processed). If bit 10 is set, the done flag has no effect.
- R5: The checks are ranked preamble, then checksum, then done flag. Only the first failing check is reported.
- R6: A descriptor that passes all three checks gets verdict 0 (accept).
- R7: `flags` on the result pulse holds word 0 bits in this order: [0]=bit 8 completion interrupt, [1]=bit 9 done write-back, [2]=bit 10 ignore done, [3]=bit 11 fixed burst, [4]=bit 18 fragmented mode, [5]=bit 19 last descriptor, [6]=bit 20 checksum enable, [7]=bit 21 last of frame.
- R8: `line_size` equals word 3 bits 17:0. `stride_bytes` equals word 3 bits 31:18 times 16.
- R9: `wb_word` returns stored word `wb_idx`, unchanged except that word 5 always has bit 31 set.
- R10: After sixteen words have been taken, further valid beats are ignored until the next start pulse. They raise no result pulse and do not alter the stored words.
- R11: A start pulse returns the word count to zero and discards a partial descriptor. A word presented in the same cycle as the start pulse is ignored.
- R12: After reset, `result_valid`, `verdict` and `flags` are 0, and the block takes the next valid word as word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Re-arm pulse: clears the word count |
| word_valid | input | 1 | A descriptor word is on `word_data` |
| word_data | input | 32 | Descriptor word |
| wb_idx | input | 4 | Word index for the write-back read port |
| wb_word | output | 32 | Stored word with done flag forced in word 5 |
| result_valid | output | 1 | One-cycle result pulse |
| verdict | output | 2 | 0 accept, 1 bad preamble, 2 checksum mismatch, 3 already processed |
| flags | output | 8 | Decoded control flags (see R7) |
| line_size | output | 18 | Line size field |
| stride_bytes | output | 18 | Line stride in bytes |

## Verification
The hardest case to reach is a descriptor where several checks fail together, so that only the ranking decides the reported verdict. A bad preamble combined with a wrong checksum and a set done flag is one example, and a correct checksum that exists only because the sum wraps past 2^32 is another. Random descriptors rarely land on these cases by chance. The stimulus therefore biases the random fields toward a valid preamble, toward a correct checksum when checksums are enabled, and toward a set done flag. Directed descriptors then add the all-fail ranking, the wrap-around sum, and a start pulse that arrives in the middle of a descriptor or together with a word.

// File: rtl/desc_chk_pkg.sv
package desc_chk_pkg;

  localparam int unsigned DW          = 32;
  localparam int unsigned DESC_WORDS  = 16;
  localparam int unsigned IDX_CTRL    = 0;
  localparam int unsigned IDX_LINE    = 3;
  localparam int unsigned IDX_DONE    = 5;
  localparam int unsigned DONE_BIT    = 31;
  localparam logic [7:0]  MAGIC       = 8'hA5;
  localparam int unsigned FLAG_W      = 8;
  localparam int unsigned LSIZE_W     = 18;
  localparam int unsigned STRIDE_W    = 18;

  typedef enum logic [1:0] {
    V_ACCEPT   = 2'd0,
    V_BAD_PRE  = 2'd1,
    V_BAD_SUM  = 2'd2,
    V_ALREADY  = 2'd3
  } verdict_t;

  function automatic logic [FLAG_W-1:0] decode_flags(input logic [DW-1:0] ctrl);
    logic [FLAG_W-1:0] f;
    f[0] = ctrl[8];
    f[1] = ctrl[9];
    f[2] = ctrl[10];
    f[3] = ctrl[11];
    f[4] = ctrl[18];
    f[5] = ctrl[19];
    f[6] = ctrl[20];
    f[7] = ctrl[21];
    return f;
  endfunction

  function automatic logic [STRIDE_W-1:0] stride_of(input logic [DW-1:0] w);
    return {w[31:18], 4'b0000};
  endfunction

  function automatic verdict_t judge(input logic [DW-1:0] ctrl,
                                     input logic [DW-1:0] sum,
                                     input logic [DW-1:0] tail,
                                     input logic [DW-1:0] done_w);
    if (ctrl[7:0] != MAGIC)                    return V_BAD_PRE;
    if (ctrl[20] && (sum != tail))             return V_BAD_SUM;
    if (done_w[DONE_BIT] && !ctrl[10])         return V_ALREADY;
    return V_ACCEPT;
  endfunction

endpackage

// File: rtl/desc_beat_counter.sv
module desc_beat_counter #(
  parameter int unsigned N_WORDS = 16,
  localparam int unsigned CNT_W  = $clog2(N_WORDS + 1),
  localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             word_valid,
  output logic             take,
  output logic             last_beat,
  output logic [IDX_W-1:0] idx
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(N_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign take      = word_valid && !start && (cnt_q != FULL);
  assign last_beat = take && (cnt_q == LAST);
  assign idx       = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (take)  cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  assert_ignore_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && !start) |=> cnt_q == FULL);

  assert_start_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == '0);

endmodule

// File: rtl/desc_word_store.sv
module desc_word_store
  import desc_chk_pkg::*;
#(
  parameter int unsigned N_WORDS = 16,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] ctrl_w,
  output logic [WORD_W-1:0] line_w,
  output logic [WORD_W-1:0] done_w,
  output logic [WORD_W-1:0] sum_q
);

  localparam logic [IDX_W-1:0] SUM_END  = IDX_W'(N_WORDS - 1);
  localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(IDX_DONE);

  logic [WORD_W-1:0] mem [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[g] <= '0;
      else if (take && idx == IDX_W'(g))   mem[g] <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else if (take && idx != SUM_END) begin
      if (idx == '0) sum_q <= data;
      else           sum_q <= sum_q + data;
    end
  end

  assign ctrl_w = mem[IDX_CTRL];
  assign line_w = mem[IDX_LINE];
  assign done_w = mem[IDX_DONE];

  always_comb begin
    rd_word = mem[rd_idx];
    if (rd_idx == DONE_IDX) rd_word[DONE_BIT] = 1'b1;
  end

  assert_wb_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == DONE_IDX) |-> rd_word[DONE_BIT]);

  assert_stable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(sum_q));

endmodule

// File: rtl/desc_verdict_reg.sv
module desc_verdict_reg
  import desc_chk_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                last_beat,
  input  logic [WORD_W-1:0]   ctrl_w,
  input  logic [WORD_W-1:0]   line_w,
  input  logic [WORD_W-1:0]   done_w,
  input  logic [WORD_W-1:0]   sum_q,
  input  logic [WORD_W-1:0]   tail_w,
  output logic                result_valid,
  output logic [1:0]          verdict,
  output logic [FLAG_W-1:0]   flags,
  output logic [LSIZE_W-1:0]  line_size,
  output logic [STRIDE_W-1:0] stride_bytes
);

  verdict_t next_v;
  assign next_v = judge(ctrl_w, sum_q, tail_w, done_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      verdict      <= '0;
      flags        <= '0;
      line_size    <= '0;
      stride_bytes <= '0;
    end else begin
      result_valid <= last_beat;
      if (last_beat) begin
        verdict      <= next_v;
        flags        <= decode_flags(ctrl_w);
        line_size    <= line_w[LSIZE_W-1:0];
        stride_bytes <= stride_of(line_w);
      end
    end
  end

  assert_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && ctrl_w[7:0] != MAGIC) |=> verdict == V_BAD_PRE);

  assert_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && ctrl_w[7:0] == MAGIC && !ctrl_w[20] && done_w[DONE_BIT] && !ctrl_w[10])
      |=> verdict == V_ALREADY);

  assert_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && ctrl_w[7:0] == MAGIC && ctrl_w[20] && sum_q != tail_w)
      |=> verdict == V_BAD_SUM);

endmodule

// File: rtl/dma_desc_checker.sv
module dma_desc_checker
  import desc_chk_pkg::*;
#(
  parameter int unsigned N_WORDS = DESC_WORDS,
  parameter int unsigned WORD_W  = DW,
  localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                word_valid,
  input  logic [WORD_W-1:0]   word_data,
  input  logic [IDX_W-1:0]    wb_idx,
  output logic [WORD_W-1:0]   wb_word,
  output logic                result_valid,
  output logic [1:0]          verdict,
  output logic [FLAG_W-1:0]   flags,
  output logic [LSIZE_W-1:0]  line_size,
  output logic [STRIDE_W-1:0] stride_bytes
);

  logic             take;
  logic             last_beat;
  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] ctrl_w, line_w, done_w, sum_q;

  desc_beat_counter #(.N_WORDS(N_WORDS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
    .take(take), .last_beat(last_beat), .idx(idx)
  );

  desc_word_store #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(word_data),
    .rd_idx(wb_idx), .rd_word(wb_word),
    .ctrl_w(ctrl_w), .line_w(line_w), .done_w(done_w), .sum_q(sum_q)
  );

  desc_verdict_reg #(.WORD_W(WORD_W)) u_verdict (
    .clk(clk), .rst_n(rst_n), .last_beat(last_beat),
    .ctrl_w(ctrl_w), .line_w(line_w), .done_w(done_w), .sum_q(sum_q),
    .tail_w(word_data),
    .result_valid(result_valid), .verdict(verdict), .flags(flags),
    .line_size(line_size), .stride_bytes(stride_bytes)
  );

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_pulse_follows_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> result_valid);

  assert_no_stray_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !last_beat |=> !result_valid);

endmodule

// File: tb/test_dma_desc_checker.sv
module test_dma_desc_checker;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        word_valid = 0;
  logic [31:0] word_data = 0;
  logic [3:0]  wb_idx = 0;
  logic [31:0] wb_word;
  logic        result_valid;
  logic [1:0]  verdict;
  logic [7:0]  flags;
  logic [17:0] line_size;
  logic [17:0] stride_bytes;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int cycles = 0;
  logic [31:0] dsc [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_checker i_dma_desc_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
    .word_data(word_data), .wb_idx(wb_idx), .wb_word(wb_word),
    .result_valid(result_valid), .verdict(verdict), .flags(flags),
    .line_size(line_size), .stride_bytes(stride_bytes)
  );

  always @(negedge clk) if (rst_n && result_valid) pulses++;

  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bench_sum();
    logic [31:0] s = 0;
    for (int i = 0; i < 15; i++) s = s + dsc[i];
    return s;
  endfunction

  function automatic logic [1:0] bench_verdict();
    logic pre_ok, sum_ok, done_ok;
    pre_ok  = (dsc[0] & 32'hFF) == 32'hA5;
    sum_ok  = !dsc[0][20] || (bench_sum() == dsc[15]);
    done_ok = dsc[0][10] || !dsc[5][31];
    if (!pre_ok) return 2'd1;
    if (!sum_ok) return 2'd2;
    if (!done_ok) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [7:0] bench_flags();
    return {dsc[0][21], dsc[0][20], dsc[0][19], dsc[0][18],
            dsc[0][11], dsc[0][10], dsc[0][9], dsc[0][8]};
  endfunction

  task automatic send_words(input bit gaps);
    for (int i = 0; i < 16; i++) begin
      if (gaps) begin
        int g = $urandom % 3;
        for (int k = 0; k < g; k++) begin
          @(negedge clk); word_valid = 0;
        end
      end
      @(negedge clk); word_valid = 1; word_data = dsc[i];
    end
  endtask

  task automatic run_desc(input bit gaps, input bit check_wb);
    send_words(gaps);
    @(negedge clk);
    word_valid = 0;
    chk("R1 pulse after last word", 32'(result_valid), 1);
    chk("R2/R3/R4/R5/R6 verdict", 32'(verdict), 32'(bench_verdict()));
    chk("R7 flags", 32'(flags), 32'(bench_flags()));
    chk("R8 line size", 32'(line_size), dsc[3] & 32'h3FFFF);
    chk("R8 stride bytes", 32'(stride_bytes), (dsc[3] >> 18) * 16);
    @(negedge clk);
    chk("R1 single cycle pulse", 32'(result_valid), 0);
    if (check_wb) begin
      for (int i = 0; i < 16; i++) begin
        wb_idx = 4'(i);
        #1;
        chk("R9 write-back word", wb_word, (i == 5) ? (dsc[i] | 32'h8000_0000) : dsc[i]);
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; word_valid = 0;
    @(negedge clk); start = 0;
  endtask

  task automatic build_random();
    for (int i = 0; i < 16; i++) dsc[i] = $urandom;
    if (($urandom % 10) < 8) dsc[0][7:0] = 8'hA5;
    dsc[0][20] = $urandom % 2;
    dsc[5][31] = ($urandom % 3) != 0;
    dsc[0][10] = ($urandom % 3) == 0;
    if (dsc[0][20] && ($urandom % 4) != 0) dsc[15] = bench_sum();
  endtask

  initial begin
    int p0;
    void'($urandom(32'h1357_9bdf));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 result_valid at reset", 32'(result_valid), 0);
    chk("R12 verdict at reset", 32'(verdict), 0);
    chk("R12 flags at reset", 32'(flags), 0);
    rst_n = 1;

    // R6 clean accept, all flags set, R12 first word after reset is word 0
    for (int i = 0; i < 16; i++) dsc[i] = 32'h1000 + i;
    dsc[0] = 32'h003C_0FA5 | 32'h0010_0000;
    dsc[3] = {14'h3FFF, 18'h2_1234};
    dsc[5][31] = 1'b0;
    dsc[15] = bench_sum();
    run_desc(0, 1);
    chk("R6 accept verdict", 32'(verdict), 0);

    // R5 all three checks fail: preamble wins
    pulse_start();
    for (int i = 0; i < 16; i++) dsc[i] = 32'hDEAD_0000 + i;
    dsc[0] = 32'h0010_005A; dsc[5][31] = 1; dsc[15] = 0;
    run_desc(0, 0);
    chk("R5 preamble ranks first", 32'(verdict), 1);

    // R5 checksum beats done flag; R3 wrap-around sum
    pulse_start();
    for (int i = 0; i < 16; i++) dsc[i] = 32'hFFFF_FFFF;
    dsc[0] = 32'h0010_00A5;
    dsc[15] = bench_sum();
    dsc[5] = 32'hFFFF_FFFF;
    dsc[15] = bench_sum() + 1;
    run_desc(0, 0);
    chk("R5 checksum ranks over done", 32'(verdict), 2);

    pulse_start();
    dsc[15] = bench_sum();
    run_desc(0, 0);
    chk("R3 wrapped sum ok, R4 done caught", 32'(verdict), 3);

    // R3 checksum off: wrong word 15 ignored
    pulse_start();
    for (int i = 0; i < 16; i++) dsc[i] = 32'h0;
    dsc[0] = 32'h0000_00A5; dsc[15] = 32'h1234_5678;
    run_desc(0, 0);
    chk("R3 sum disabled ignored", 32'(verdict), 0);

    // R4 ignore done override
    pulse_start();
    dsc[5] = 32'h8000_0000; dsc[0] = 32'h0000_04A5;
    run_desc(0, 1);
    chk("R4 ignore-done accepts", 32'(verdict), 0);

    // R10 extra words ignored
    p0 = pulses;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); word_valid = 1; word_data = 32'hBAD0_0000 + k;
    end
    @(negedge clk); word_valid = 0;
    @(negedge clk);
    chk("R10 no pulse for extra words", 32'(pulses), 32'(p0));
    wb_idx = 0; #1;
    chk("R10 word 0 unchanged", wb_word, dsc[0]);
    wb_idx = 15; #1;
    chk("R10 word 15 unchanged", wb_word, dsc[15]);

    // R11 start mid-descriptor, word with start ignored
    pulse_start();
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); word_valid = 1; word_data = 32'h5555_0000 + k;
    end
    @(negedge clk); start = 1; word_valid = 1; word_data = 32'hFFFF_FF5A;
    @(negedge clk); start = 0; word_valid = 0;
    p0 = pulses;
    build_random();
    run_desc(1, 1);
    chk("R11 one pulse after restart", 32'(pulses), 32'(p0 + 1));

    // random descriptors
    for (int n = 0; n < 200; n++) begin
      pulse_start();
      build_random();
      run_desc(1, (n % 10) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule